// File: doc/BRIEF.md
# Completion-Order Sequence Checker

This block watches three subsystems, A, B and C. Each one raises a one-cycle completion pulse when its task ends. After all three have finished, a separate check strobe arrives. In the cycle of that strobe the checker decides whether the round was clean. A round is clean when exactly one pulse came from each subsystem, the pulses came one per cycle, and they came in the order A, then B, then C. If the round was not clean, the checker drives a one-cycle error output.

The check strobe also clears everything the checker has tracked. The next round of three completions then starts from the initial state. Once a round has gone wrong, the checker stays in a held error state until the next check strobe. A synchronous reset puts the checker back to waiting for A at any time.

Top module: `seq_chk_top`

## Requirements
- R1: A synchronous reset, with `rst` high at a rising edge, puts the checker in the waiting-for-A state. This is so whether or not a round was partly done. After reset, a check with no completions gives `err`=1, and a clean round gives `err`=0.
- R2: Single pulses on `doneA`, `doneB` and `doneC`, in that order, in separate cycles, with any number of idle cycles between them, followed by `check`, give `err`=0 in the check cycle.
- R3: A round in which the first pulse of each subsystem comes in any order other than A, B, C gives `err`=1 in the check cycle.
- R4: A second completion pulse from any subsystem within a round gives `err`=1 at the check.
- R5: A check that arrives before all three completions have been seen gives `err`=1.
- R6: Two or three completion pulses in the same cycle are an order error, and give `err`=1 at the check.
- R7: `err` is high only in a cycle in which `check` is high, and it is low in every other cycle.
- R8: `check` re-arms the checker. The round after a check is judged on its own, whatever the result of the round before it.
- R9: Once an order error has occurred, later pulses do not clear it, even pulses that complete a correct-looking A, B, C tail. The error state is held until `check`.
- R10: A completion pulse in the same cycle as `check` makes that check report `err`=1, and it is not carried into the next round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| doneA | input | 1 | Completion pulse from subsystem A |
| doneB | input | 1 | Completion pulse from subsystem B |
| doneC | input | 1 | Completion pulse from subsystem C |
| check | input | 1 | End-of-round strobe: judges the round and re-arms the checker |
| err | output | 1 | One-cycle order-error flag, valid in the check cycle |

## Verification
The assertions assume that `rst` is driven to a known level from the first clock edge. They also assume that the completion and check inputs are single-cycle strobes sampled on the rising edge, and that nothing else is needed. The stimulus changes every input only on the falling edge. It holds `rst` high over the first two edges, and it samples `err` shortly after each input change, while the state from the last edge is stable. The rounds run back to back, often with no idle cycle between a check and the next pulse. This puts the re-arm path and the same-cycle check-plus-pulse case under the properties.

// File: rtl/seq_chk_pkg.sv
package seq_chk_pkg;
  localparam int NUM_SRC = 3;
  localparam int ST_W = $clog2(NUM_SRC + 2);

  // Waiting states are numbered by the index of the source expected next.
  typedef enum logic [ST_W-1:0] {
    ST_WAIT_A   = 3'd0,
    ST_WAIT_B   = 3'd1,
    ST_WAIT_C   = 3'd2,
    ST_ALL_DONE = 3'd3,
    ST_BAD      = 3'd4
  } chkState_t;

  typedef struct packed {
    logic               anyDone;
    logic               multiDone;
    logic [NUM_SRC-1:0] hit;
  } pulseEv_t;

  typedef struct packed {
    logic roundClean;
  } ctlStrobe_t;
endpackage

// File: rtl/seq_chk_datapath.sv
module seq_chk_datapath
  import seq_chk_pkg::*;
(
  input  logic       doneA,
  input  logic       doneB,
  input  logic       doneC,
  input  logic       check,
  input  ctlStrobe_t ctl,
  output pulseEv_t   ev,
  output logic       err
);
  logic [NUM_SRC-1:0] doneVec;
  logic [NUM_SRC:0]   anyChain;
  logic [NUM_SRC:0]   multiChain;

  assign doneVec = {doneC, doneB, doneA};

  assign anyChain[0]   = 1'b0;
  assign multiChain[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_reduce
    assign anyChain[i+1]   = anyChain[i] | doneVec[i];
    assign multiChain[i+1] = multiChain[i] | (anyChain[i] & doneVec[i]);
  end

  always_comb begin
    ev.hit       = doneVec;
    ev.anyDone   = anyChain[NUM_SRC];
    ev.multiDone = multiChain[NUM_SRC];
  end

  // A pulse in the check cycle spoils an otherwise clean round.
  assign err = check & ~(ctl.roundClean & ~ev.anyDone);
endmodule

// File: rtl/seq_chk_control.sv
module seq_chk_control
  import seq_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       check,
  input  pulseEv_t   ev,
  output ctlStrobe_t ctl,
  output chkState_t  stateQ
);
  chkState_t stateD;
  logic [NUM_SRC-1:0] expectHit;

  always_comb begin
    expectHit = '0;
    if (stateQ < ST_ALL_DONE) expectHit[stateQ[1:0]] = 1'b1;
  end

  always_comb begin
    stateD = stateQ;
    if (check) begin
      stateD = ST_WAIT_A;
    end else if (ev.anyDone) begin
      if (ev.multiDone || stateQ >= ST_ALL_DONE || ev.hit != expectHit)
        stateD = ST_BAD;
      else
        stateD = chkState_t'(stateQ + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_WAIT_A;
    else     stateQ <= stateD;
  end

  assign ctl.roundClean = (stateQ == ST_ALL_DONE);
endmodule

// File: rtl/seq_chk_top.sv
module seq_chk_top
  import seq_chk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic doneA,
  input  logic doneB,
  input  logic doneC,
  input  logic check,
  output logic err
);
  pulseEv_t   ev;
  ctlStrobe_t ctl;
  chkState_t  ctlState;

  seq_chk_datapath u_dp (
    .doneA(doneA), .doneB(doneB), .doneC(doneC), .check(check),
    .ctl(ctl), .ev(ev), .err(err)
  );

  seq_chk_control u_ctl (
    .clk(clk), .rst(rst), .check(check), .ev(ev),
    .ctl(ctl), .stateQ(ctlState)
  );
endmodule

// File: rtl/seq_chk_sva.sv
module seq_chk_sva
  import seq_chk_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      doneA,
  input logic      doneB,
  input logic      doneC,
  input logic      check,
  input logic      err,
  input chkState_t ctlState
);
  p_reset_wait_a_r1: assert property (@(posedge clk)
    rst |=> ctlState == ST_WAIT_A);

  p_err_only_on_check_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> check);

  p_check_rearms_r8: assert property (@(posedge clk) disable iff (rst)
    check |=> ctlState == ST_WAIT_A);

  p_error_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_BAD && !check) |=> ctlState == ST_BAD);

  p_simultaneous_bad_r6: assert property (@(posedge clk) disable iff (rst)
    (!check && $countones({doneA, doneB, doneC}) > 1) |=> ctlState == ST_BAD);

  p_clean_needs_c_r2: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_WAIT_C && !check && doneC && !doneA && !doneB)
      |=> ctlState == ST_ALL_DONE);

  p_pulse_with_check_r10: assert property (@(posedge clk) disable iff (rst)
    (check && (doneA || doneB || doneC)) |-> err);
endmodule

bind seq_chk_top seq_chk_sva u_sva (.*);

// File: tb/seq_chk_top_test.sv
module seq_chk_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 40;
  // Entry: {tag[3:0], doneA, doneB, doneC, check, expectedErr}
  localparam logic [8:0] VEC [NVEC] = '{
    // R2 clean round with idle gaps, err low outside check (R7)
    {4'd2,5'b10000},{4'd7,5'b00000},{4'd2,5'b01000},{4'd2,5'b00100},{4'd2,5'b00000},{4'd2,5'b00010},
    // R3 B before A
    {4'd3,5'b01000},{4'd3,5'b10000},{4'd3,5'b00100},{4'd3,5'b00011},
    // R8 clean round right after an error round
    {4'd8,5'b10000},{4'd8,5'b01000},{4'd8,5'b00100},{4'd8,5'b00010},
    // R4 duplicate A
    {4'd4,5'b10000},{4'd4,5'b10000},{4'd4,5'b01000},{4'd4,5'b00100},{4'd4,5'b00011},
    // R5 C missing
    {4'd5,5'b10000},{4'd5,5'b01000},{4'd5,5'b00011},
    // R6 A and B together, then all three together
    {4'd6,5'b11000},{4'd6,5'b00100},{4'd6,5'b00011},
    {4'd6,5'b11100},{4'd6,5'b00011},
    // R9 C first, then a full A,B,C tail
    {4'd9,5'b00100},{4'd9,5'b10000},{4'd9,5'b01000},{4'd9,5'b00100},{4'd9,5'b00011},
    // R10 C arrives with check, then a clean round
    {4'd10,5'b10000},{4'd10,5'b01000},{4'd10,5'b00111},
    {4'd10,5'b10000},{4'd10,5'b01000},{4'd10,5'b00100},{4'd10,5'b00010},
    // R5 check with nothing seen
    {4'd5,5'b00011}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic doneA = 1'b0, doneB = 1'b0, doneC = 1'b0, check = 1'b0;
  logic err;
  int nChecks = 0;
  int nFails = 0;
  logic testDone = 1'b0;

  seq_chk_top uut (.clk(clk), .rst(rst), .doneA(doneA), .doneB(doneB),
                   .doneC(doneC), .check(check), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [3:0] p);
    @(negedge clk);
    {doneA, doneB, doneC, check} = p;
    #2;
  endtask

  task automatic expect_err(input logic exp, input string tag);
    nChecks++;
    if (err !== exp) begin
      nFails++;
      $display("FAIL %s: err=%b expected %b at %0t", tag, err, exp, $time);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state: nothing completed, check must flag
    drive(4'b0001); expect_err(1'b1, "R1");
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][4:1]);
      expect_err(VEC[i][0], tagName(VEC[i][8:5]));
    end
    // R1 reset in the middle of a round restarts from waiting-for-A
    drive(4'b1000); drive(4'b0100);
    @(negedge clk) rst = 1'b1; {doneA, doneB, doneC, check} = 4'b0000;
    @(negedge clk) rst = 1'b0;
    drive(4'b1000); expect_err(1'b0, "R1");
    drive(4'b0100); drive(4'b0010);
    drive(4'b0001); expect_err(1'b0, "R1");
    // R7 err stays low with check low, even in a broken round
    drive(4'b0010); expect_err(1'b0, "R7");
    drive(4'b0000); expect_err(1'b0, "R7");
    drive(4'b0001); expect_err(1'b1, "R3");
    // R8 back-to-back checks: the second sees an empty round
    drive(4'b0001); expect_err(1'b1, "R8");
    drive(4'b0000);
    testDone = 1'b1;
  end

  initial begin
    fork
      wait (testDone);
      begin
        repeat (2000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule